// File: doc/BRIEF.md
# Three-Phase Dual-Ramp PWM Controller

The block drives a three-phase power stage through six PWM outputs. There are three modules, and each one owns two outputs. A single 12-bit counter serves as the shared timebase. Each PWM cycle has two halves. In the first half, only each module's A output can be active. In the second half, only its B output can be active. The height of each sweep is set by a programmable top value. Each output has its own compare value, so the duty of all six outputs is set independently. The output is high while the counter is below its compare value.

Software loads settings through a one-cycle write port. The settings are the top value, the sweep mode and the six compare values. Every write goes into a staging register first. Staged values move into the active set only when the B half of a cycle ends, so a cycle already running is never disturbed. A one-clock strobe marks each transfer.

Each module has a fault input. An asserted fault pulls both of that module's outputs low without waiting for a clock. The fault is then latched until software clears it. While the fault is latched, that module's compare values are not transferred.

Top module: `pwm3_ramp_ctrl`

## Requirements
- R1: In ramp mode (mode bit 0 = 0), each half counts 0,1,...,top and then restarts at 0. Each half takes top+1 clocks and a full cycle takes 2*(top+1) clocks.
- R2: In centered mode (mode bit 0 = 1), each half sweeps 0 up to top and back down to 0. Each half takes 2*top+1 clocks and a full cycle takes 2*(2*top+1) clocks.
- R3: The mode bit is one setting that applies to all three modules together.
- R4: Output A of module m is high while the counter is below its compare value, during the A half only. Output B works the same way during the B half. Per cycle, the high time is min(cmp, top+1) clocks in ramp mode. In centered mode it is 0 if cmp=0, 2*top+1 if cmp>top, and 2*cmp otherwise.
- R5: The A half always comes first and the B half second. No A output is ever high during the B half, and no B output is ever high during the A half.
- R6: The register map is as follows:
  - address 0 is the top value, with reset value 15;
  - address 1 bit 0 is the mode;
  - address 2+m is the A compare value of module m;
  - address 5+m is the B compare value of module m;
  - address 8 clears a latched fault, with bit m of the data clearing module m.
- R7: A write never changes the cycle in progress. Staged values become active on the first clock after the B half ends.
- R8: The update strobe is high for exactly one clock at the start of every cycle, when the counter is 0 in the A half, and at no other time.
- R9: Asserting fault input m forces both outputs of module m low in the same clock. The other modules are not affected.
- R10: A fault stays latched after its input falls, until a clear is written for that module. A clear written while the fault input is still high is ignored.
- R11: While module m is faulted, its compare values are not transferred at a cycle end. The values that were active before the fault stay in use until a cycle end with no fault.
- R12: After a synchronous reset, all outputs and the strobe are low, the counter is 0 in the A half, and all compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| fault_in | input | 3 | Per-module fault request, one bit per module |
| pwm_a | output | 3 | A outputs, one bit per module |
| pwm_b | output | 3 | B outputs, one bit per module |
| upd_pulse | output | 1 | One-clock strobe at each settings transfer |

## Verification
Settings are loaded while the previous setting drives the outputs, so every cycle measured also shows that in-flight writes have no effect. The vectors cover:
- both modes with different top values;
- compare values of zero, compare values inside the sweep, compare values equal to top, and compare values above top.

These separate a full-on output, a full-off output and a proportional duty, and ramp timing from centered timing. Each cycle's high clocks are counted separately for each half, which shows whether a pulse leaked into the wrong half. The distance between strobes shows the cycle length. A directed fault sequence does the following:
- checks the same-clock blanking;
- writes a clear while the fault is still held;
- stages a new compare value during the fault;
- clears the fault at the start of a cycle, so that the old compare value, still active, can be told apart from the staged one.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CW      = 12;
    localparam int NMOD    = 3;
    localparam logic [CW-1:0] TOP_RST = 12'd15;

    typedef enum logic {
        RUN_RAMP   = 1'b0,
        RUN_CENTER = 1'b1
    } run_mode_e;

    typedef enum logic {
        SUB_A = 1'b0,
        SUB_B = 1'b1
    } sub_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [CW-1:0] cmp_a;
        logic [CW-1:0] cmp_b;
    } cmp_pair_t;

    // address of the A or B compare register of module m
    function automatic int cmp_addr(input int nmod, input int m, input logic is_b);
        return 2 + m + (is_b ? nmod : 0);
    endfunction

endpackage

// File: rtl/pwm3_regbank.sv
module pwm3_regbank
    import pwm3_pkg::*;
#(
    parameter int N_MOD  = NMOD,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CW-1:0]          wr_data,
    output logic [CW-1:0]          top_stg,
    output run_mode_e              mode_stg,
    output cmp_pair_t [N_MOD-1:0]  cmp_stg,
    output logic [N_MOD-1:0]       fclr
);

    localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(2 + 2 * N_MOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_stg  <= TOP_RST;
            mode_stg <= RUN_RAMP;
            cmp_stg  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_TOP)
                top_stg <= wr_data;
            if (wr_addr == A_MODE)
                mode_stg <= run_mode_e'(wr_data[0]);
            for (int m = 0; m < N_MOD; m++) begin
                if (wr_addr == ADDR_W'(cmp_addr(N_MOD, m, 1'b0)))
                    cmp_stg[m].cmp_a <= wr_data;
                if (wr_addr == ADDR_W'(cmp_addr(N_MOD, m, 1'b1)))
                    cmp_stg[m].cmp_b <= wr_data;
            end
        end
    end

    always_comb begin
        fclr = '0;
        if (wr_en && wr_addr == A_FCLR)
            fclr = wr_data[N_MOD-1:0];
    end

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] top_stg,
    input  run_mode_e     mode_stg,
    output logic [CW-1:0] cnt,
    output sub_e          sub,
    output logic          cyc_end,
    output logic          upd_pulse
);

    logic [CW-1:0] top_act;
    run_mode_e     mode_act;
    dir_e          dir;
    logic          sweep_end;

    // end of one half: ramp ends at top, centered ends back at zero
    always_comb begin
        if (mode_act == RUN_RAMP)
            sweep_end = (cnt == top_act);
        else if (dir == DIR_UP)
            sweep_end = (cnt == top_act) && (top_act == '0);
        else
            sweep_end = (cnt == '0);
    end

    assign cyc_end = sweep_end && (sub == SUB_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sub       <= SUB_A;
            dir       <= DIR_UP;
            top_act   <= TOP_RST;
            mode_act  <= RUN_RAMP;
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= cyc_end;
            if (cyc_end) begin
                cnt      <= '0;
                sub      <= SUB_A;
                dir      <= DIR_UP;
                top_act  <= top_stg;
                mode_act <= mode_stg;
            end else if (sweep_end) begin
                cnt <= '0;
                sub <= SUB_B;
                dir <= DIR_UP;
            end else if (mode_act == RUN_CENTER && dir == DIR_UP && cnt == top_act) begin
                dir <= DIR_DOWN;
                cnt <= cnt - CW'(1);
            end else if (dir == DIR_DOWN) begin
                cnt <= cnt - CW'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= top_act);

    assert_ramp_step_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_act == RUN_RAMP && !sweep_end) |=> cnt == $past(cnt) + CW'(1));

    assert_center_down_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_act == RUN_CENTER && dir == DIR_DOWN && cnt != '0)
            |=> (cnt == $past(cnt) - CW'(1)) && dir == DIR_DOWN);

    assert_upd_single_R8: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);

    assert_upd_start_R8: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> (cnt == '0 && sub == SUB_A));

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  sub_e          sub,
    input  logic          cyc_end,
    input  cmp_pair_t     cmp_stg,
    input  logic          fault_in,
    input  logic          fclr,
    output logic          pwm_a,
    output logic          pwm_b
);

    cmp_pair_t cmp_act;
    logic      flt_lat;
    logic      faulted;

    assign faulted = fault_in | flt_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act <= '0;
            flt_lat <= 1'b0;
        end else begin
            if (fault_in)
                flt_lat <= 1'b1;
            else if (fclr)
                flt_lat <= 1'b0;
            if (cyc_end && !faulted)
                cmp_act <= cmp_stg;
        end
    end

    assign pwm_a = !faulted && (sub == SUB_A) && (cnt < cmp_act.cmp_a);
    assign pwm_b = !faulted && (sub == SUB_B) && (cnt < cmp_act.cmp_b);

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (rst)
        fault_in |-> (!pwm_a && !pwm_b));

    assert_fault_kept_R10: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> (!pwm_a && !pwm_b));

    assert_a_in_a_R5: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_B) |-> !pwm_a);

    assert_b_in_b_R5: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_A) |-> !pwm_b);

    assert_commit_edge_R7: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> $stable(cmp_act));

    assert_hold_fault_R11: assert property (@(posedge clk) disable iff (rst)
        (faulted && cyc_end) |=> $stable(cmp_act));

endmodule

// File: rtl/pwm3_ramp_ctrl.sv
module pwm3_ramp_ctrl
    import pwm3_pkg::*;
#(
    parameter int N_MOD  = NMOD,
    parameter int ADDR_W = $clog2(2 * N_MOD + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [N_MOD-1:0]  fault_in,
    output logic [N_MOD-1:0]  pwm_a,
    output logic [N_MOD-1:0]  pwm_b,
    output logic              upd_pulse
);

    logic [CW-1:0]         top_stg;
    run_mode_e             mode_stg;
    cmp_pair_t [N_MOD-1:0] cmp_stg;
    logic [N_MOD-1:0]      fclr;
    logic [CW-1:0]         cnt;
    sub_e                  sub;
    logic                  cyc_end;

    pwm3_regbank #(
        .N_MOD  (N_MOD),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .top_stg  (top_stg),
        .mode_stg (mode_stg),
        .cmp_stg  (cmp_stg),
        .fclr     (fclr)
    );

    pwm3_timebase u_tbase (
        .clk       (clk),
        .rst       (rst),
        .top_stg   (top_stg),
        .mode_stg  (mode_stg),
        .cnt       (cnt),
        .sub       (sub),
        .cyc_end   (cyc_end),
        .upd_pulse (upd_pulse)
    );

    for (genvar m = 0; m < N_MOD; m++) begin : g_phase
        pwm3_phase u_phase (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt),
            .sub      (sub),
            .cyc_end  (cyc_end),
            .cmp_stg  (cmp_stg[m]),
            .fault_in (fault_in[m]),
            .fclr     (fclr[m]),
            .pwm_a    (pwm_a[m]),
            .pwm_b    (pwm_b[m])
        );
    end

    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> (pwm_a == '0 && pwm_b == '0 && !upd_pulse));

endmodule

// File: tb/pwm3_ramp_ctrl_bench.sv
module pwm3_ramp_ctrl_bench;

    typedef struct packed {
        logic        mode;
        logic [11:0] top;
        logic [11:0] a0, a1, a2, b0, b1, b2;
    } vec_t;

    // mode, top, A compares of modules 0..2, B compares of modules 0..2
    localparam vec_t VECS [5] = '{
        '{1'b0, 12'd10, 12'd0,  12'd5,  12'd11, 12'd3, 12'd10, 12'd20},
        '{1'b1, 12'd8,  12'd4,  12'd9,  12'd0,  12'd1, 12'd8,  12'd12},
        '{1'b0, 12'd5,  12'd6,  12'd2,  12'd1,  12'd5, 12'd0,  12'd3},
        '{1'b1, 12'd6,  12'd7,  12'd3,  12'd6,  12'd2, 12'd0,  12'd5},
        '{1'b0, 12'd20, 12'd20, 12'd21, 12'd7,  12'd0, 12'd19, 12'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  fault_in = '0;
    logic [2:0]  pwm_a, pwm_b;
    logic        upd_pulse;

    int errors = 0;
    int checks = 0;
    int a1[3], a2[3], b1[3], b2[3];
    int upd_extra;
    logic upd_end;

    always #4 clk = ~clk;

    pwm3_ramp_ctrl u_pwm3_ramp_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fault_in  (fault_in),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b),
        .upd_pulse (upd_pulse)
    );

    function automatic int hi_count(input logic mode, input int top, input int c);
        if (!mode) return (c < top + 1) ? c : top + 1;
        if (c == 0) return 0;
        if (c > top) return 2 * top + 1;
        return 2 * c;
    endfunction

    function automatic int cyc_len(input logic mode, input int top);
        return mode ? 2 * (2 * top + 1) : 2 * (top + 1);
    endfunction

    task automatic chk_eq(input string msg, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // one register write, R6 map
    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_vec(input vec_t v);
        wr(4'd0, v.top);
        wr(4'd1, {11'd0, v.mode});
        wr(4'd2, v.a0); wr(4'd3, v.a1); wr(4'd4, v.a2);
        wr(4'd5, v.b0); wr(4'd6, v.b1); wr(4'd7, v.b2);
    endtask

    task automatic wait_update();
        @(negedge clk);
        while (!upd_pulse) @(negedge clk);
    endtask

    // starts on the negedge where the strobe is seen, ends on the next one
    task automatic measure(input int len);
        for (int m = 0; m < 3; m++) begin
            a1[m] = 0; a2[m] = 0; b1[m] = 0; b2[m] = 0;
        end
        upd_extra = 0;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            for (int m = 0; m < 3; m++) begin
                if (pwm_a[m]) begin if (k < len / 2) a1[m]++; else a2[m]++; end
                if (pwm_b[m]) begin if (k < len / 2) b1[m]++; else b2[m]++; end
            end
            if (k > 0 && upd_pulse) upd_extra++;
        end
        @(negedge clk);
        upd_end = upd_pulse;
    endtask

    task automatic check_cycle(input vec_t v, input string ctx);
        int ea[3], eb[3];
        ea[0] = hi_count(v.mode, int'(v.top), int'(v.a0));
        ea[1] = hi_count(v.mode, int'(v.top), int'(v.a1));
        ea[2] = hi_count(v.mode, int'(v.top), int'(v.a2));
        eb[0] = hi_count(v.mode, int'(v.top), int'(v.b0));
        eb[1] = hi_count(v.mode, int'(v.top), int'(v.b1));
        eb[2] = hi_count(v.mode, int'(v.top), int'(v.b2));
        for (int m = 0; m < 3; m++) begin
            chk_eq($sformatf("%s %s A duty mod %0d", ctx, v.mode ? "R3 R4" : "R4", m), a1[m], ea[m]);
            chk_eq($sformatf("%s %s B duty mod %0d", ctx, v.mode ? "R3 R4" : "R4", m), b2[m], eb[m]);
            chk_eq($sformatf("R5 A in B half mod %0d", m), a2[m], 0);
            chk_eq($sformatf("R5 B in A half mod %0d", m), b1[m], 0);
        end
        chk_eq("R8 strobe inside cycle", upd_extra, 0);
        chk_eq(v.mode ? "R2 centered cycle length" : "R1 ramp cycle length", int'(upd_end), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t prev;
        int hi;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R12 reset pwm_a", int'(pwm_a), 0);
        chk_eq("R12 reset pwm_b", int'(pwm_b), 0);
        chk_eq("R12 reset strobe", int'(upd_pulse), 0);
        rst = 1'b0;
        wait_update();
        prev = '{1'b0, 12'd15, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0};

        // table walk: each cycle is measured with the previous settings while new ones are written
        for (int i = 0; i < 5; i++) begin
            fork
                measure(cyc_len(prev.mode, int'(prev.top)));
                write_vec(VECS[i]);
            join
            check_cycle(prev, "R7 R6");
            prev = VECS[i];
        end
        measure(cyc_len(prev.mode, int'(prev.top)));
        check_cycle(prev, "R6");

        // fault on module 1 at the start of a cycle (last vector active, top 20, ramp)
        fault_in = 3'b010;
        #1;
        chk_eq("R9 faulted pwm_a[1] low", int'(pwm_a[1]), 0);
        chk_eq("R9 faulted pwm_b[1] low", int'(pwm_b[1]), 0);
        chk_eq("R9 module 0 unaffected", int'(pwm_a[0]), 1);
        wr(4'd8, 12'd2);          // R10 clear while input still high: ignored
        wr(4'd3, 12'd2);          // staged A compare for module 1
        fault_in = 3'b000;
        hi = 0;
        while (!upd_pulse) begin
            if (pwm_a[1] || pwm_b[1]) hi++;
            @(negedge clk);
        end
        chk_eq("R10 latched after input falls", hi, 0);
        measure(42);
        chk_eq("R10 module 1 A still blank", a1[1], 0);
        chk_eq("R10 module 1 B still blank", b2[1], 0);
        chk_eq("R9 module 0 A normal", a1[0], 20);

        // clear at start of a cycle: held old compare (21) must be in use
        wr(4'd8, 12'd2);
        hi = 0;
        for (int k = 1; k < 21; k++) begin
            if (pwm_a[1]) hi++;
            @(negedge clk);
        end
        chk_eq("R11 held compare used after clear", hi, 20);
        wait_update();
        measure(42);
        chk_eq("R11 staged compare commits after clear", a1[1], 2);
        chk_eq("R11 B compare of module 1", b2[1], 19);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule